// File: doc/BRIEF.md
# Master-Clocked Serial Result Port for a Sampling Converter

This block is the digital back end of a converter's serial output when the converter supplies its own bit clock. It receives each 16-bit conversion result together with the conversion-start pulse and the busy level. It then produces three outputs: a divided-down serial clock, a framing strobe that marks the valid data window, and a data line that carries the word with the most significant bit first.

The port works only when serial operation and internally generated clocking are both selected. When the externally clocked option is selected, the port simply stays quiet. Chip select and read enable are active-low and gate the port. Either line going high while a frame is running abandons that frame.

Two read timings are available. In the first, a frame starts as soon as busy falls and carries the word that has just been converted. In the second, a frame starts with the next conversion request and carries the word captured when the previous conversion ended. The clock polarity and the strobe polarity can each be inverted independently.

Top module: `adc_serial_master`

## Requirements
- R1: While `ser_sel` is 0, `sdo` is 0, `sclk_o` equals `inv_sclk` and `sync_o` equals `inv_sync`, and no frame is produced.
- R2: While `ext_clk` is 1, the outputs hold the same idle levels as in R1 and no frame is produced.
- R3: A completed frame contains exactly 16 logical clock pulses, and the data bit present at the k-th pulse is bit 15-k of the word.
- R4: The logical strobe (`sync_o` XOR `inv_sync`) is 1 during the whole frame and 0 outside it, and the logical clock (`sclk_o` XOR `inv_sclk`) is never 1 while the logical strobe is 0.
- R5: `inv_sclk`=1 inverts `sclk_o` and `inv_sync`=1 inverts `sync_o`, both at idle and during a frame, and the transmitted word is the same under every polarity setting.
- R6: `sdo` holds one value across both the rising and the falling edge of each logical clock pulse.
- R7: With `rd_after`=1, a frame starts after `busy` falls and carries the `result` value present in the cycle in which `busy` was first seen low.
- R8: With `rd_after`=0, a frame starts on `conv_start` and carries the `result` value captured at the most recent fall of `busy` (0 after reset).
- R9: While `cs_n` or `rd_n` is 1, the outputs are idle and no frame starts. Raising either line during a frame ends that frame at once, and the frame does not resume.
- R10: A `conv_start` that arrives while a frame is running does not start a new frame and does not disturb the running one, and `overrun` is 1 for exactly the next cycle.
- R11: In the logical clock, consecutive rising edges are 2*HALF_DIV system clocks apart, and each high phase lasts HALF_DIV system clocks.
- R12: After reset, `sclk_o`, `sync_o`, `sdo` and `overrun` are 0 when both polarity inputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_sel | input | 1 | 1 selects serial operation |
| ext_clk | input | 1 | 1 selects external clocking (port idles) |
| rd_after | input | 1 | 1 = read after conversion, 0 = read during next conversion |
| inv_sclk | input | 1 | Inverts the serial clock |
| inv_sync | input | 1 | Inverts the frame strobe |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read enable |
| conv_start | input | 1 | Conversion-start pulse |
| busy | input | 1 | Conversion in progress |
| result | input | DATA_W | Conversion result |
| sclk_o | output | 1 | Serial clock |
| sync_o | output | 1 | Frame strobe |
| sdo | output | 1 | Serial data |
| overrun | output | 1 | One-cycle pulse when a request is ignored |

## Verification
The hardest situation to reach is a second conversion request that lands inside a running frame. In that case the bench must show two things: the running frame still delivers the old word with all 16 pulses, and no second frame follows. The bench reaches this state in the read-during-conversion timing. It issues a request, lets `busy` fall partway through the frame, and issues a second request while the strobe is still active. It then checks the one-cycle overrun pulse, the word that was delivered, and the frame count long after the event. A separate case pulls chip select high partway through a frame and confirms that the strobe drops at once and the frame does not resume.

// File: rtl/adcsm_pkg.sv
package adcsm_pkg;
   typedef enum logic {
      RD_DURING = 1'b0,
      RD_AFTER  = 1'b1
   } rd_mode_e;

   function automatic int frame_cycles(input int width, input int half_div);
      return width * 2 * half_div;
   endfunction
endpackage

// File: rtl/adcsm_hold.sv
module adcsm_hold #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy,
   input  logic [DATA_W-1:0] din,
   output logic              busy_fall,
   output logic [DATA_W-1:0] hold
);
   logic busy_q;

   assign busy_fall = busy_q & ~busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         hold   <= '0;
      end else begin
         busy_q <= busy;
         if (busy_fall) hold <= din;
      end
   end
endmodule

// File: rtl/adcsm_bitclk.sv
module adcsm_bitclk #(
   parameter int DATA_W   = 16,
   parameter int HALF_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic sclk_raw,
   output logic shift_en,
   output logic done
);
   localparam int PERIOD = 2 * HALF_DIV;
   localparam int PW     = $clog2(PERIOD);
   localparam int BW     = $clog2(DATA_W);

   logic [PW-1:0] phase;
   logic [BW-1:0] bitc;
   logic          wrap, last_bit;

   assign wrap     = (phase == PW'(PERIOD - 1));
   assign last_bit = (bitc == BW'(DATA_W - 1));
   assign sclk_raw = run && (phase >= PW'(1)) && (phase <= PW'(HALF_DIV));
   assign shift_en = run && wrap && !last_bit;
   assign done     = run && wrap && last_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= '0;
         bitc  <= '0;
      end else if (!run) begin
         phase <= '0;
         bitc  <= '0;
      end else if (wrap) begin
         phase <= '0;
         bitc  <= bitc + BW'(1);
      end else begin
         phase <= phase + PW'(1);
      end
   end
endmodule

// File: rtl/adcsm_shift.sv
module adcsm_shift #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] din,
   input  logic              shift,
   output logic              msb
);
   logic [DATA_W-1:0] sh;

   assign msb = sh[DATA_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sh <= '0;
      else if (load)  sh <= din;
      else if (shift) sh <= {sh[DATA_W-2:0], 1'b0};
   end
endmodule

// File: rtl/adc_serial_master.sv
module adc_serial_master #(
   parameter int DATA_W   = 16,
   parameter int HALF_DIV = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_sel,
   input  logic              ext_clk,
   input  logic              rd_after,
   input  logic              inv_sclk,
   input  logic              inv_sync,
   input  logic              cs_n,
   input  logic              rd_n,
   input  logic              conv_start,
   input  logic              busy,
   input  logic [DATA_W-1:0] result,
   output logic              sclk_o,
   output logic              sync_o,
   output logic              sdo,
   output logic              overrun
);
   import adcsm_pkg::*;

   localparam int FRAME_CYC = frame_cycles(DATA_W, HALF_DIV);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("adc_serial_master: DATA_W must be 2 or more");
      end
      if (HALF_DIV < 2) begin : g_bad_div
         $error("adc_serial_master: HALF_DIV must be 2 or more");
      end
      if (FRAME_CYC < 4) begin : g_bad_frame
         $error("adc_serial_master: frame too short");
      end
   endgenerate

   rd_mode_e          mode;
   logic              en, busy_fall, trig, load, active;
   logic              sclk_raw, shift_en, done, msb, ovr_q;
   logic [DATA_W-1:0] hold, load_word;

   assign mode      = rd_mode_e'(rd_after);
   assign en        = ser_sel & ~ext_clk & ~cs_n & ~rd_n;
   assign trig      = (mode == RD_AFTER) ? busy_fall : conv_start;
   assign load      = en & ~active & trig;
   assign load_word = (mode == RD_AFTER) ? result : hold;

   adcsm_hold #(.DATA_W(DATA_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .busy(busy), .din(result),
      .busy_fall(busy_fall), .hold(hold)
   );

   adcsm_bitclk #(.DATA_W(DATA_W), .HALF_DIV(HALF_DIV)) u_bitclk (
      .clk(clk), .rst_n(rst_n), .run(active),
      .sclk_raw(sclk_raw), .shift_en(shift_en), .done(done)
   );

   adcsm_shift #(.DATA_W(DATA_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(load), .din(load_word),
      .shift(shift_en), .msb(msb)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         ovr_q  <= 1'b0;
      end else begin
         ovr_q <= en & active & conv_start;
         if (!en)        active <= 1'b0;
         else if (load)  active <= 1'b1;
         else if (done)  active <= 1'b0;
      end
   end

   assign sclk_o  = (sclk_raw & en) ^ inv_sclk;
   assign sync_o  = (active & en) ^ inv_sync;
   assign sdo     = active & en & msb;
   assign overrun = ovr_q;
endmodule

// File: rtl/adcsm_chk.sv
module adcsm_chk (
   input logic clk,
   input logic rst_n,
   input logic ser_sel,
   input logic ext_clk,
   input logic inv_sclk,
   input logic inv_sync,
   input logic cs_n,
   input logic rd_n,
   input logic conv_start,
   input logic sclk_o,
   input logic sync_o,
   input logic sdo,
   input logic overrun
);
   logic sync_l, sclk_l;
   assign sync_l = sync_o ^ inv_sync;
   assign sclk_l = sclk_o ^ inv_sclk;

   // R1
   ser_off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ser_sel |-> (!sync_l && !sclk_l && !sdo));
   // R2
   ext_clk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_clk |-> (!sync_l && !sclk_l && !sdo));
   // R9
   gate_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n || rd_n) |-> (!sync_l && !sclk_l && !sdo));
   // R4
   clk_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sclk_l |-> sync_l);
   // R6
   rise_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_l && $rose(sclk_l)) |-> $stable(sdo));
   // R6
   fall_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_l && $fell(sclk_l)) |-> $stable(sdo));
   // R10
   overrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_l && conv_start) |=> overrun);
   // R10
   overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |-> $past(sync_l && conv_start));
endmodule

bind adc_serial_master adcsm_chk u_chk (
   .clk(clk), .rst_n(rst_n), .ser_sel(ser_sel), .ext_clk(ext_clk),
   .inv_sclk(inv_sclk), .inv_sync(inv_sync), .cs_n(cs_n), .rd_n(rd_n),
   .conv_start(conv_start), .sclk_o(sclk_o), .sync_o(sync_o),
   .sdo(sdo), .overrun(overrun)
);

// File: tb/sim_adc_serial_master.sv
`timescale 1ns/1ps
module sim_adc_serial_master;
   localparam int HD = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic ser_sel = 1'b1, ext_clk = 1'b0, rd_after = 1'b1;
   logic inv_sclk = 1'b0, inv_sync = 1'b0, cs_n = 1'b0, rd_n = 1'b0;
   logic conv_start = 1'b0, busy = 1'b0;
   logic [15:0] result = '0;
   logic sclk_o, sync_o, sdo, overrun;

   int n_chk = 0, n_bad = 0, cyc = 0;
   int frames = 0, pulses = 0, last_pulses = 0, last_rise = 0;
   logic rise_seen = 1'b0, bitv = 1'b0, sl_p = 1'b0, kl_p = 1'b0;
   logic [15:0] cap = '0, last_word = '0, prev_res = '0;
   bit done_flag = 1'b0;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   adc_serial_master #(.DATA_W(16), .HALF_DIV(HD)) u0 (
      .clk(clk), .rst_n(rst_n), .ser_sel(ser_sel), .ext_clk(ext_clk),
      .rd_after(rd_after), .inv_sclk(inv_sclk), .inv_sync(inv_sync),
      .cs_n(cs_n), .rd_n(rd_n), .conv_start(conv_start), .busy(busy),
      .result(result), .sclk_o(sclk_o), .sync_o(sync_o), .sdo(sdo),
      .overrun(overrun)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
      end
   endtask

   task automatic finish_up();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   // frame monitor on logical levels
   always @(negedge clk) begin
      logic sl, kl;
      sl = sync_o ^ inv_sync;
      kl = sclk_o ^ inv_sclk;
      if (rst_n) begin
         if (sl && !sl_p) begin cap = '0; pulses = 0; rise_seen = 1'b0; end
         if (sl && kl && !kl_p) begin
            cap = {cap[14:0], sdo};
            pulses++;
            bitv = sdo;
            if (rise_seen) check(cyc - last_rise == 2*HD, "R11 period", cyc - last_rise, 2*HD);
            last_rise = cyc;
            rise_seen = 1'b1;
         end
         if (sl && !kl && kl_p) begin
            check(sdo == bitv, "R6 data moved at falling edge", sdo, bitv);
            check(cyc - last_rise == HD, "R11 high width", cyc - last_rise, HD);
         end
         if (kl && !sl) check(1'b0, "R4 clock outside frame", kl, 0);
         if (!sl && sl_p) begin frames++; last_word = cap; last_pulses = pulses; end
      end
      sl_p = sl;
      kl_p = kl;
   end

   task automatic wait_frame(input int f0);
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (frames != f0) break;
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic run_conv(input logic [15:0] d, input logic mode, input int blen,
                           input bit expect_frame, input string req);
      int f0;
      logic [15:0] exp;
      f0  = frames;
      exp = mode ? d : prev_res;
      @(negedge clk);
      rd_after = mode; conv_start = 1'b1; busy = 1'b1;
      @(negedge clk);
      conv_start = 1'b0;
      repeat (blen) @(negedge clk);
      result = d; busy = 1'b0; prev_res = d;
      wait_frame(f0);
      if (expect_frame) begin
         check(frames == f0 + 1, {req, " frame count"}, frames - f0, 1);
         check(last_word == exp, {req, mode ? " R7 word" : " R8 word"}, last_word, exp);
         check(last_pulses == 16, {req, " R3 pulses"}, last_pulses, 16);
      end else begin
         check(frames == f0, {req, " no frame"}, frames - f0, 0);
         check(sdo == 1'b0 && sclk_o == inv_sclk && sync_o == inv_sync,
               {req, " idle outputs"}, {sdo, sclk_o, sync_o}, {1'b0, inv_sclk, inv_sync});
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      check(1'b0, "R3 watchdog expired", 0, 1);
      finish_up();
   end

   initial begin
      int f0;
      void'($urandom(32'h5EED_0421));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      check(sclk_o == 0 && sync_o == 0 && sdo == 0 && overrun == 0, "R12 reset",
            {sclk_o, sync_o, sdo, overrun}, 0);

      // R7 / R3 directed words
      run_conv(16'hA5C3, 1'b1, 12, 1'b1, "R7");
      run_conv(16'h8001, 1'b1, 5, 1'b1, "R3");
      run_conv(16'hFFFF, 1'b1, 20, 1'b1, "R7");
      run_conv(16'h0000, 1'b1, 8, 1'b1, "R3");

      // R8 read during the next conversion
      run_conv(16'h1234, 1'b0, 10, 1'b1, "R8");
      run_conv(16'h5678, 1'b0, 30, 1'b1, "R8");

      // R5 polarity
      inv_sclk = 1'b1;
      @(negedge clk);
      check(sclk_o == 1'b1 && sync_o == 1'b0, "R5 sclk inverted idle", {sclk_o, sync_o}, 2'b10);
      inv_sync = 1'b1;
      @(negedge clk);
      check(sync_o == 1'b1, "R5 sync inverted idle", sync_o, 1);
      run_conv(16'h3C5A, 1'b1, 9, 1'b1, "R5");
      run_conv(16'hC0DE, 1'b0, 9, 1'b1, "R5");
      inv_sclk = 1'b0; inv_sync = 1'b0;

      // R1 parallel selected
      ser_sel = 1'b0;
      run_conv(16'h7777, 1'b1, 6, 1'b0, "R1");
      ser_sel = 1'b1;
      // R2 external clock selected
      ext_clk = 1'b1;
      run_conv(16'h2222, 1'b1, 6, 1'b0, "R2");
      ext_clk = 1'b0;
      // R9 chip select / read gating
      cs_n = 1'b1;
      run_conv(16'h4444, 1'b1, 6, 1'b0, "R9");
      cs_n = 1'b0; rd_n = 1'b1;
      run_conv(16'h6666, 1'b0, 6, 1'b0, "R9");
      rd_n = 1'b0;

      // R9 abort partway through a frame
      f0 = frames;
      @(negedge clk); rd_after = 1'b1; conv_start = 1'b1; busy = 1'b1;
      @(negedge clk); conv_start = 1'b0;
      repeat (6) @(negedge clk);
      result = 16'h9ABC; busy = 1'b0; prev_res = 16'h9ABC;
      repeat (20) @(negedge clk);
      check(sync_o == 1'b1, "R9 frame running before abort", sync_o, 1);
      cs_n = 1'b1;
      @(negedge clk);
      check(sync_o == 1'b0 && sclk_o == 1'b0 && sdo == 1'b0, "R9 abort idle",
            {sync_o, sclk_o, sdo}, 0);
      cs_n = 1'b0;
      repeat (150) @(negedge clk);
      check(frames == f0 + 1 && last_pulses < 16, "R9 no resume", frames - f0, 1);

      // R10 request during a running frame
      f0 = frames;
      @(negedge clk); rd_after = 1'b0; conv_start = 1'b1; busy = 1'b1;
      @(negedge clk); conv_start = 1'b0;
      repeat (8) @(negedge clk);
      result = 16'hBEEF; busy = 1'b0;
      repeat (10) @(negedge clk);
      check(overrun == 1'b0, "R10 no overrun yet", overrun, 0);
      conv_start = 1'b1;
      @(negedge clk);
      conv_start = 1'b0;
      check(overrun == 1'b1, "R10 overrun pulse", overrun, 1);
      @(negedge clk);
      check(overrun == 1'b0, "R10 overrun one cycle", overrun, 0);
      wait_frame(f0);
      check(last_word == prev_res && last_pulses == 16, "R10 frame kept", last_word, prev_res);
      repeat (150) @(negedge clk);
      check(frames == f0 + 1, "R10 no second frame", frames - f0, 1);
      prev_res = 16'hBEEF;

      // random mix over R3 R5 R7 R8
      for (int i = 0; i < 40; i++) begin
         logic [15:0] d;
         logic m;
         d = 16'($urandom);
         m = 1'($urandom);
         @(negedge clk);
         inv_sclk = 1'($urandom);
         inv_sync = 1'($urandom);
         run_conv(d, m, 3 + int'($urandom % 40), 1'b1, m ? "R7 rnd" : "R8 rnd");
      end
      finish_up();
   end
endmodule